// File: doc/BRIEF.md
# Test Access Port Controller with Capture-Only Boundary Register

This block is the serial test port of a memory device. It runs the sixteen-state test access port state machine from the test clock and mode-select input. It holds a four-bit instruction register and three data paths: a one-bit bypass stage, an optional 32-bit identification register, and a boundary register that takes a snapshot of a parallel vector of device pin values. Mode select and serial input are sampled on the rising test clock edge. The serial output is launched from the falling edge.

The boundary register can only take snapshots. Passing through Update-DR loads nothing and drives no pin, so it has the same effect as a pause. The external-test code selects the boundary register but drives nothing. Every code without a function routes the data path through the bypass stage and has no side effect. An optional asynchronous active-low reset forces the controller into Test-Logic-Reset. Five rising edges with mode select high do the same.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The controller state changes only on a rising `tck` edge and follows the standard 16-state transition graph selected by `tms`.
- R2: From any state, five consecutive rising edges with `tms` high put the controller in Test-Logic-Reset. `trst_n` low forces Test-Logic-Reset at once, without waiting for a clock edge.
- R3: Entering Test-Logic-Reset loads the identification code 4'b0001 into the instruction register. If no identification register is built, it loads the bypass code 4'b1111 instead.
- R4: Capture-IR loads 4'b0001 into the instruction shift stage, with the low two bits fixed at 01. The stage is shifted out least significant bit first.
- R5: A shifted-in instruction takes effect only in Update-IR.
- R6: With code 4'b0001, Capture-DR loads the 32-bit identification value. It is shifted out least significant bit first.
- R7: With code 4'b0010 (sample) or 4'b0000 (external test), Capture-DR loads every bit of `pins`, including any clock pin, into the boundary register. Bit 0 comes out first.
- R8: Update-DR leaves the instruction and the boundary register unchanged. Under sample, the next capture returns fresh pin values and never the shifted-in data.
- R9: With code 4'b1111, the path is one bit long. It captures 0 and delays `tdi` by one shift cycle.
- R10: Every code other than 0000, 0001, 0010 and 1111 behaves exactly like the bypass code.
- R11: `tdo` and `tdo_en` change only on a falling `tck` edge. `tdo_en` is high only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pins | input | BSR_W | Device pin values captured by the boundary register |
| tdo | output | 1 | Serial data out, launched on falling `tck` |
| tdo_en | output | 1 | Output enable for `tdo`; low models the tri-state condition |

## Verification
The embedded assertions check the following on every rising edge:
- the reset-load of the instruction register;
- the fixed capture pattern of the instruction stage;
- that the instruction changes only at Update-IR;
- that registers hold through Update-DR;
- that five high mode-select edges reach Test-Logic-Reset;
- that the output enable agrees with the shift states.

Some behaviour can only be shown from the pins, so the bench scenarios cover it. These are the serial contents of each data path, the capture of random pin vectors, and the one-cycle bypass delay under both defined and undefined codes. They also show that data shifted in under sample never comes back as a preload, and that the output changes only at the falling edge. A random walk of the state machine is compared against an independent transition model.

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl #(
  parameter int          BSR_W    = 8,
  parameter bit          HAS_ID   = 1'b1,
  parameter logic [31:0] ID_VALUE = 32'h0B2C_E0D3
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  input  logic [BSR_W-1:0] pins,
  output logic             tdo,
  output logic             tdo_en
);
  localparam int         IR_W      = 4;
  localparam logic [3:0] C_EXTEST  = 4'b0000;
  localparam logic [3:0] C_IDCODE  = 4'b0001;
  localparam logic [3:0] C_SAMPLE  = 4'b0010;
  localparam logic [3:0] C_BYPASS  = 4'b1111;
  localparam logic [3:0] RESET_IR  = HAS_ID ? C_IDCODE : C_BYPASS;
  localparam logic [IR_W-1:0] IR_CAP = {{(IR_W-2){1'b0}}, 2'b01};

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PA_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PA_IR, S_EX2_IR, S_UPD_IR
  } tap_t;

  tap_t             state, nxt;
  logic [IR_W-1:0]  ir, ir_sh;
  logic [BSR_W-1:0] bsr;
  logic [31:0]      idr;
  logic             byp, tdo_q, en_q;

  always_comb begin
    case (state)
      S_TLR:    nxt = tms ? S_TLR    : S_RTI;
      S_RTI:    nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nxt = tms ? S_UPD_DR : S_PA_DR;
      S_PA_DR:  nxt = tms ? S_EX2_DR : S_PA_DR;
      S_EX2_DR: nxt = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nxt = tms ? S_UPD_IR : S_PA_IR;
      S_PA_IR:  nxt = tms ? S_EX2_IR : S_PA_IR;
      S_EX2_IR: nxt = tms ? S_UPD_IR : S_SH_IR;
      default:  nxt = tms ? S_SEL_DR : S_RTI;
    endcase
  end

  wire sel_bsr = (ir == C_SAMPLE) || (ir == C_EXTEST);
  wire sel_id  = HAS_ID && (ir == C_IDCODE);
  wire dr_lsb  = sel_bsr ? bsr[0] : (sel_id ? idr[0] : byp);
  wire in_shift = (state == S_SH_DR) || (state == S_SH_IR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state <= S_TLR;
      ir    <= RESET_IR;
      ir_sh <= IR_CAP;
      bsr   <= '0;
      idr   <= '0;
      byp   <= 1'b0;
    end else begin
      state <= nxt;
      case (state)
        S_TLR:    ir <= RESET_IR;
        S_CAP_IR: ir_sh <= IR_CAP;
        S_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        S_UPD_IR: ir <= ir_sh;
        S_CAP_DR: begin
          byp <= 1'b0;
          if (sel_bsr) bsr <= pins;
          if (sel_id)  idr <= ID_VALUE;
        end
        S_SH_DR: begin
          if (sel_bsr)     bsr <= {tdi, bsr[BSR_W-1:1]};
          else if (sel_id) idr <= {tdi, idr[31:1]};
          else             byp <= tdi;
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      en_q <= in_shift;
      if (state == S_SH_IR)      tdo_q <= ir_sh[0];
      else if (state == S_SH_DR) tdo_q <= dr_lsb;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_en = en_q;

  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)  tms_run <= 3'd0;
    else if (!tms) tms_run <= 3'd0;
    else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
  end

  p_five_ones_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (tms_run == 3'd5) |-> (state == S_TLR));
  p_reset_ir_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_TLR) |=> (ir == RESET_IR));
  p_ir_capture_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CAP_IR) |=> (ir_sh[1:0] == 2'b01));
  p_ir_update_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (state != S_UPD_IR && state != S_TLR) |=> $stable(ir));
  p_ir_load_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_UPD_IR) |=> (ir == $past(ir_sh)));
  p_update_dr_inert_r8: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_UPD_DR) |=> ($stable(bsr) && $stable(ir)));
  p_bypass_zero_r9: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CAP_DR) |=> !byp);
  p_enable_shift_r11: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == in_shift);
endmodule

// File: tb/jtag_tap_ctrl_test.sv
module jtag_tap_ctrl_test;
  localparam int CLK_P = 20;
  localparam int BW = 8;
  localparam logic [31:0] IDV = 32'h0B2C_E0D3;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [BW-1:0] pins = '0;
  wire tdo, tdo_en;
  int checks = 0, fails = 0;
  int st;

  jtag_tap_ctrl #(.BSR_W(BW), .HAS_ID(1'b1), .ID_VALUE(IDV)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pins(pins),
    .tdo(tdo), .tdo_en(tdo_en));

  always #(CLK_P/2) tck = ~tck;

  function automatic int nx(int s, logic m);
    case (s)
      0: return m ? 0 : 1;    1: return m ? 2 : 1;
      2: return m ? 9 : 3;    3: return m ? 5 : 4;
      4: return m ? 5 : 4;    5: return m ? 8 : 6;
      6: return m ? 7 : 6;    7: return m ? 8 : 4;
      8: return m ? 2 : 1;    9: return m ? 0 : 10;
      10: return m ? 12 : 11; 11: return m ? 12 : 11;
      12: return m ? 15 : 13; 13: return m ? 14 : 13;
      14: return m ? 15 : 11; default: return m ? 2 : 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    logic pre;
    tms = m; tdi = d;
    pre = tdo;
    @(posedge tck); #1;
    chk(tdo === pre, "R11 tdo held at rising edge", {63'b0, tdo}, {63'b0, pre});
    st = nx(st, m);
    @(negedge tck); #1;
    chk(tdo_en === (st == 4 || st == 11), "R1 R11 enable vs state model",
        {63'b0, tdo_en}, {63'b0, (st == 4 || st == 11)});
  endtask

  task automatic scan(input bit ir_path, input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0);
    if (ir_path) step(1, 0);
    step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n-1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic load_ir(input logic [3:0] code);
    logic [63:0] o;
    scan(1, 4, {60'b0, code}, o);
    chk(o[3:0] == 4'b0001, "R4 IR capture pattern", o, 64'h1);
  endtask

  task automatic check_bypass(input string req);
    logic [63:0] din, o, e;
    din = {$urandom, $urandom};
    scan(0, 16, din, o);
    e = {48'b0, din[14:0], 1'b0};
    chk(o[15:0] == e[15:0], req, o & 64'hFFFF, e);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] o;
    logic [BW-1:0] pv;
    logic [3:0] code;
    void'($urandom(32'd5150));
    st = 0;
    #(CLK_P * 2 + 3);
    chk(tdo_en === 1'b0, "R11 enable low in reset", {63'b0, tdo_en}, 64'h0);
    @(negedge tck); #1; trst_n = 1'b1;
    step(0, 0);
    // R3 R6: reset instruction is the identification code
    scan(0, 32, 64'h0, o);
    chk(o[31:0] == IDV, "R3 R6 identification after reset", o, {32'b0, IDV});
    // R7 capture random pins under sample and external test
    for (int k = 0; k < 6; k++) begin
      load_ir((k % 2) ? 4'b0000 : 4'b0010);
      pv = BW'($urandom); pins = pv;
      scan(0, BW, 64'($urandom), o);
      chk(o[BW-1:0] == pv, "R7 boundary capture", o, 64'(pv));
      // R8 next capture returns fresh pins, not shifted-in data
      pv = ~pv; pins = pv;
      scan(0, BW, 64'hA5, o);
      chk(o[BW-1:0] == pv, "R8 no preload after Update-DR", o, 64'(pv));
    end
    // R9 bypass
    load_ir(4'b1111);
    check_bypass("R9 bypass one-bit delay");
    // R10 reserved codes
    for (int k = 0; k < 8; k++) begin
      do code = 4'($urandom); while (code == 4'b0000 || code == 4'b0001 || code == 4'b0010 || code == 4'b1111);
      load_ir(code);
      check_bypass("R10 reserved code acts as bypass");
    end
    // R5 instruction change observed after Update-IR
    load_ir(4'b0001);
    scan(0, 32, 64'h0, o);
    chk(o[31:0] == IDV, "R5 identification after Update-IR", o, {32'b0, IDV});
    // R1 R2 random walks then five ones
    for (int k = 0; k < 20; k++) begin
      load_ir(4'b1111);
      for (int j = 0; j < 30; j++) step(1'($urandom), 1'($urandom));
      for (int j = 0; j < 5; j++) step(1, 0);
      chk(st == 0, "R2 model reached reset", 64'(st), 64'h0);
      step(0, 0);
      scan(0, 32, 64'h0, o);
      chk(o[31:0] == IDV, "R2 R3 five ones reset IR", o, {32'b0, IDV});
    end
    // R2 asynchronous reset mid-shift
    load_ir(4'b1111);
    step(1, 0); step(0, 0); step(0, 0);
    #3; trst_n = 1'b0; #2;
    chk(tdo_en === 1'b0, "R2 async reset clears enable", {63'b0, tdo_en}, 64'h0);
    @(negedge tck); #1; trst_n = 1'b1; st = 0;
    step(0, 0);
    scan(0, 32, 64'h0, o);
    chk(o[31:0] == IDV, "R2 R3 async reset IR", o, {32'b0, IDV});
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule